// File: doc/BRIEF.md
# Frame-Synced Byte Serial Port (Master)

This block is the master end of a synchronous serial link that moves single bytes. It makes the serial clock from the system clock, drives its own transmit frame-sync pulse and transmit data line, and takes in receive data framed by a separate receive sync that the far end supplies. Because the two directions have their own syncs, one direction can carry many bytes while the other carries none.

On the parallel side, bytes to send enter through a valid/ready stream port. A source raises `tx_valid` with `tx_data` and holds both unchanged until it sees `tx_ready` high on a system clock edge. `tx_ready` never depends on `tx_valid`. While a byte waits or is being shifted, the port takes the next byte only in the one system cycle that opens the current byte's last bit. A byte offered in that cycle goes out with no gap; a byte that misses it waits until the link has gone idle. Received bytes leave on `rx_data` with a single-cycle `rx_valid` strobe and no back-pressure.

The link parks the serial clock low when there is nothing to do. `hold_clk` keeps the clock running without transmit traffic, so the far end can send. `enable` low switches the whole port off at once.

Top module: `fsync_byte_port`

## Requirements
- R1: After reset, `sclk`, `tx_fs`, `tx_sd` and `rx_valid` are low, and `tx_ready` is high while `enable` is high.
- R2: While the clock runs, each half period of `sclk` lasts `half_div`+1 system clock cycles. `half_div` is held constant while the link is active.
- R3: A byte accepted while the link is idle is sent as follows. In the first serial clock `tx_fs` is low. In the second clock `tx_fs` is high (sync). The next eight clocks carry the byte on `tx_sd`, most significant bit first and bit 0 last. `tx_fs` and `tx_sd` change only on the system edge where `sclk` rises, and the far end samples them on the falling edge.
- R4: A byte accepted in the ready cycle that opens the current byte's bit-0 clock raises `tx_fs` during that bit-0 clock. Its MSB goes out in the very next clock, so successive syncs are exactly eight clocks apart.
- R5: With `hold_clk` low and no next byte, one more clock follows bit 0 with `tx_fs` and `tx_sd` low, and then `sclk` stays low. A lone byte sent from idle therefore takes 11 serial clocks.
- R6: With `hold_clk` high, the clock starts from idle and keeps running with `tx_fs` and `tx_sd` low until a byte is offered. That byte's sync comes at least one clock after the clock starts.
- R7: When `rx_fs` is high at a falling edge of `sclk`, the next eight falling edges sample `rx_sd` as bit 7 down to bit 0. The byte then appears on `rx_data` with `rx_valid` high for exactly one system cycle.
- R8: If `rx_fs` is sampled high together with bit 0, the next received byte starts at the following falling edge. Receive framing works whether or not transmit bytes are flowing.
- R9: When `enable` goes low, `sclk`, `tx_fs`, `tx_sd` and `tx_ready` are low from the next system cycle. A byte that was accepted but not yet sent is discarded, and a partly received byte is dropped. After re-enable, nothing is sent until a new byte is offered.
- R10: A byte transfers on a system edge where `tx_valid` and `tx_ready` are both high. From the acceptance of a byte until that byte ends, `tx_ready` is high only in the single system cycle that opens the byte's bit-0 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Port on; low stops the clock and clears both directions |
| hold_clk | input | 1 | Keep the serial clock running with no transmit byte |
| half_div | input | DIV_W | Serial clock half period minus one, in system cycles |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` holds a byte to send |
| tx_ready | output | 1 | Port takes the byte on this edge if valid |
| sclk | output | 1 | Serial clock, parked low when idle |
| tx_fs | output | 1 | Transmit frame sync, high during the clock before an MSB |
| tx_sd | output | 1 | Transmit serial data |
| rx_fs | input | 1 | Receive frame sync from the far end |
| rx_sd | input | 1 | Receive serial data |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` is new |

## Verification
The hardest case to reach from the ports is the gap-free hand-over. `tx_ready` reopens for only one system cycle, inside the clock that carries the current byte's bit 0. The bench therefore keeps `tx_valid` high across a three-byte burst, so each following byte is present when that cycle comes. It loops the transmit lines back into the receiver, so the sync that comes with bit 0 also checks the back-to-back receive path. Receive-only traffic needs a running clock with no transmit byte. The bench holds the clock on and drives its own two-byte receive stream from a script timed on serial clock edges.

// File: rtl/fsb_pkg.sv
`timescale 1ns/1ps
package fsb_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam int LEFT_W    = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,   // clock parked
    ST_WAKE,   // counting up to the first rising edge
    ST_FILL,   // clock running, sync and data low
    ST_SYNC,   // sync clock ahead of a fresh MSB
    ST_DATA,   // shifting the byte
    ST_TAIL    // closing clock, then park
  } tx_state_t;
endpackage

// File: rtl/fsb_sclk_gen.sv
`timescale 1ns/1ps
module fsb_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             park,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt;
  logic             edge_due;

  assign edge_due = run && (cnt == half_div);
  assign rise_stb = edge_due && !sclk;
  assign fall_stb = edge_due && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (edge_due) begin
      cnt <= '0;
      if (sclk || !park) sclk <= !sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: a parked clock that is low never rises again
  p_parked_stays_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && park && !sclk) |=> !sclk);

  // R2: the clock moves only when a half period has elapsed
  p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !edge_due && $stable(run)) |=> $stable(sclk));
endmodule

// File: rtl/fsb_tx_shifter.sv
`timescale 1ns/1ps
module fsb_tx_shifter
  import fsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hold_clk,
  input  logic              rise_stb,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_fs,
  output logic              tx_sd,
  output logic              active,
  output logic              parking
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);
  localparam logic [BIT_CNT_W-1:0] PREV_BIT = BIT_CNT_W'(BYTE_W - 2);

  tx_state_t             state;
  logic [BYTE_W-1:0]     shreg;
  logic [BIT_CNT_W-1:0]  cnt;
  logic                  pend;
  logic                  take;
  logic                  d0_open;

  assign d0_open  = (state == ST_DATA) && (cnt == PREV_BIT) && rise_stb;
  assign tx_ready = enable && !pend &&
                    ((state == ST_IDLE) || (state == ST_WAKE) ||
                     (state == ST_FILL) || d0_open);
  assign take     = tx_valid && tx_ready;
  assign active   = (state != ST_IDLE);
  assign parking  = (state == ST_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      shreg <= '0;
      cnt   <= '0;
      pend  <= 1'b0;
      tx_fs <= 1'b0;
      tx_sd <= 1'b0;
    end else if (!enable) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
      tx_fs <= 1'b0;
      tx_sd <= 1'b0;
    end else begin
      if (take && state != ST_DATA) begin
        shreg <= tx_data;
        pend  <= 1'b1;
      end
      unique case (state)
        ST_IDLE: if (take || hold_clk) state <= ST_WAKE;
        ST_WAKE: if (rise_stb) state <= ST_FILL;
        ST_FILL: if (rise_stb) begin
          if (pend || take) begin
            state <= ST_SYNC;
            tx_fs <= 1'b1;
            pend  <= 1'b0;
          end else if (!hold_clk) begin
            state <= ST_TAIL;
          end
        end
        ST_SYNC: if (rise_stb) begin
          state <= ST_DATA;
          tx_fs <= 1'b0;
          tx_sd <= shreg[BYTE_W-1];
          shreg <= {shreg[BYTE_W-2:0], 1'b0};
          cnt   <= '0;
        end
        ST_DATA: if (rise_stb) begin
          if (cnt == LAST_BIT) begin
            if (tx_fs) begin
              tx_fs <= 1'b0;
              tx_sd <= shreg[BYTE_W-1];
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              cnt   <= '0;
            end else begin
              tx_sd <= 1'b0;
              state <= hold_clk ? ST_FILL : ST_TAIL;
            end
          end else begin
            tx_sd <= shreg[BYTE_W-1];
            cnt   <= cnt + 1'b1;
            if (d0_open && take) begin
              shreg <= tx_data;
              tx_fs <= 1'b1;
            end else begin
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_TAIL: if (rise_stb) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: sync only in the sync clock or in a bit-0 clock
  p_sync_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fs |-> ((state == ST_SYNC) || (state == ST_DATA && cnt == LAST_BIT)));

  // R3: line changes only on a rising serial edge
  p_rise_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !rise_stb) |=> ($stable(tx_fs) && $stable(tx_sd)));

  // R10: a byte taken from idle starts the clock
  p_take_wakes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && take) |=> (state == ST_WAKE));

  // R9: switching off quiets the lines at once
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!tx_fs && !tx_sd && state == ST_IDLE));
endmodule

// File: rtl/fsb_rx_shifter.sv
`timescale 1ns/1ps
module fsb_rx_shifter
  import fsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fall_stb,
  input  logic              rx_fs,
  input  logic              rx_sd,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid
);
  logic [BYTE_W-1:0] sh;
  logic [LEFT_W-1:0] left;
  logic              busy;
  logic [BYTE_W-1:0] next_sh;

  assign busy    = (left != '0);
  assign next_sh = {sh[BYTE_W-2:0], rx_sd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      left     <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!enable) begin
        left <= '0;
      end else if (fall_stb) begin
        if (busy) begin
          sh <= next_sh;
          if (left == LEFT_W'(1)) begin
            rx_data  <= next_sh;
            rx_valid <= 1'b1;
          end
        end
        if (rx_fs)     left <= LEFT_W'(BYTE_W);
        else if (busy) left <= left - 1'b1;
      end
    end
  end

  // R7: strobe lasts one cycle
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7: a byte completes only on a falling serial edge
  p_strobe_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(fall_stb));
endmodule

// File: rtl/fsync_byte_port.sv
`timescale 1ns/1ps
module fsync_byte_port
  import fsb_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hold_clk,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              sclk,
  output logic              tx_fs,
  output logic              tx_sd,
  input  logic              rx_fs,
  input  logic              rx_sd,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid
);
  logic tx_active;
  logic tx_parking;
  logic run;
  logic rise_stb;
  logic fall_stb;

  assign run = enable && tx_active;

  fsb_sclk_gen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .park     (tx_parking),
    .half_div (half_div),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  fsb_tx_shifter u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .hold_clk (hold_clk),
    .rise_stb (rise_stb),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_fs    (tx_fs),
    .tx_sd    (tx_sd),
    .active   (tx_active),
    .parking  (tx_parking)
  );

  fsb_rx_shifter u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .fall_stb (fall_stb),
    .rx_fs    (rx_fs),
    .rx_sd    (rx_sd),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  // R9 / R5: an inactive link always shows a low clock
  p_idle_clock_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !sclk);
endmodule

// File: tb/fsync_byte_port_bench.sv
`timescale 1ns/1ps
module fsync_byte_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       hold_clk = 1'b0;
  logic [7:0] half_div = 8'd1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, sclk, tx_fs, tx_sd, rx_fs, rx_sd, rx_valid;
  logic [7:0] rx_data;
  logic       loop_on = 1'b1;
  logic       rx_fs_drv = 1'b0;
  logic       rx_sd_drv = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign rx_fs = loop_on ? tx_fs : rx_fs_drv;
  assign rx_sd = loop_on ? tx_sd : rx_sd_drv;

  fsync_byte_port u_fsync_byte_port (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hold_clk(hold_clk),
    .half_div(half_div), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .sclk(sclk), .tx_fs(tx_fs), .tx_sd(tx_sd),
    .rx_fs(rx_fs), .rx_sd(rx_sd), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  // serial line log
  int     nclk = 0;
  longint rise_t [256];
  logic   fs_log [256];
  logic   sd_log [256];
  always @(posedge sclk) begin
    if (nclk < 256) rise_t[nclk] = $time;
    nclk = nclk + 1;
  end
  always @(negedge sclk) begin
    if (nclk > 0 && nclk <= 256) begin
      fs_log[nclk-1] = tx_fs;
      sd_log[nclk-1] = tx_sd;
    end
  end

  // received byte log
  int         nrx = 0;
  logic [7:0] rx_log [64];
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (nrx < 64) rx_log[nrx] = rx_data;
      nrx = nrx + 1;
    end
  end

  // scripted far-end transmitter: sync in clocks 2 and 10, bytes 81h and 7Eh
  logic slave_on = 1'b0;
  int   slave_c = 0;
  localparam logic [7:0] RX_A = 8'h81;
  localparam logic [7:0] RX_B = 8'h7E;
  always @(posedge sclk) begin
    if (slave_on) begin
      slave_c = slave_c + 1;
      rx_fs_drv = (slave_c == 2) || (slave_c == 10);
      if (slave_c >= 3 && slave_c <= 10)       rx_sd_drv = RX_A[10 - slave_c];
      else if (slave_c >= 11 && slave_c <= 18) rx_sd_drv = RX_B[18 - slave_c];
      else                                     rx_sd_drv = 1'b0;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    nclk = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 24) begin
      @(negedge clk);
      if (sclk) q = 0; else q++;
    end
  endtask

  task automatic check_byte_bits(input string tag, input int first, input logic [7:0] b);
    for (int i = 0; i < 8; i++) check(tag, sd_log[first + i], b[7 - i]);
  endtask

  task automatic t_reset();
    check("R1 sclk low", sclk, 0);
    check("R1 tx_fs low", tx_fs, 0);
    check("R1 tx_sd low", tx_sd, 0);
    check("R1 rx_valid low", rx_valid, 0);
    check("R1 tx_ready high", tx_ready, 1);
  endtask

  task automatic t_single();
    int pulses = 0;
    int rx0;
    half_div = 8'd1; loop_on = 1'b1; hold_clk = 1'b0;
    rx0 = nrx;
    clear_logs();
    send_byte(8'hA5);
    while (nclk < 11) begin
      @(negedge clk);
      if (tx_ready) pulses++;
    end
    wait_quiet();
    check("R10 one ready pulse during byte", pulses, 1);
    check("R5 clocks for lone byte", nclk, 11);
    check("R3 lead clock sync low", fs_log[0], 0);
    check("R3 sync clock", fs_log[1], 1);
    for (int i = 2; i < 11; i++) check("R3 no extra sync", fs_log[i], 0);
    check_byte_bits("R3 MSB-first bits", 2, 8'hA5);
    check("R5 tail clock data low", sd_log[10], 0);
    check("R5 clock parked", sclk, 0);
    check("R2 period half_div=1", rise_t[1] - rise_t[0], 16);
    check("R7 loopback byte count", nrx - rx0, 1);
    check("R7 loopback byte", rx_log[rx0], 8'hA5);
  endtask

  task automatic t_burst();
    logic [7:0] bytes [3];
    int rx0;
    bytes[0] = 8'h96; bytes[1] = 8'h0F; bytes[2] = 8'hE1;
    half_div = 8'd3; loop_on = 1'b1; hold_clk = 1'b0;
    rx0 = nrx;
    clear_logs();
    tx_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tx_data = bytes[k];
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
    end
    tx_valid = 1'b0;
    wait_quiet();
    check("R4 clocks for three bytes", nclk, 27);
    for (int i = 0; i < 27; i++)
      check("R4 sync positions", fs_log[i], (i == 1 || i == 9 || i == 17) ? 1 : 0);
    for (int k = 0; k < 3; k++) check_byte_bits("R4 gapless bits", 2 + 8 * k, bytes[k]);
    check("R2 period half_div=3", rise_t[1] - rise_t[0], 32);
    check("R8 back-to-back rx count", nrx - rx0, 3);
    for (int k = 0; k < 3; k++) check("R8 back-to-back rx byte", rx_log[rx0 + k], bytes[k]);
    half_div = 8'd1;
  endtask

  task automatic t_hold_rx();
    int rx0;
    int n;
    int lines;
    loop_on = 1'b0; half_div = 8'd1;
    rx0 = nrx;
    clear_logs();
    slave_c = 0; slave_on = 1'b1;
    @(negedge clk);
    hold_clk = 1'b1;
    while (nclk < 22) @(negedge clk);
    slave_on = 1'b0; rx_fs_drv = 1'b0; rx_sd_drv = 1'b0;
    hold_clk = 1'b0;
    wait_quiet();
    n = nclk;
    lines = 0;
    for (int i = 0; i < n && i < 256; i++) lines += fs_log[i] + sd_log[i];
    check("R6 clock ran without byte", n >= 22, 1);
    check("R6 lines low while filling", lines, 0);
    check("R8 rx-only byte count", nrx - rx0, 2);
    check("R7 rx-only first byte", rx_log[rx0], RX_A);
    check("R8 rx-only second byte", rx_log[rx0 + 1], RX_B);
    loop_on = 1'b1;
  endtask

  task automatic t_hold_tx();
    int k = -1;
    int syncs = 0;
    int rx0;
    loop_on = 1'b1; half_div = 8'd1;
    rx0 = nrx;
    clear_logs();
    hold_clk = 1'b1;
    while (nclk < 3) @(negedge clk);
    send_byte(8'h3C);
    while (nclk < 20) @(negedge clk);
    hold_clk = 1'b0;
    wait_quiet();
    for (int i = 0; i < nclk && i < 256; i++)
      if (fs_log[i]) begin
        syncs++;
        if (k < 0) k = i;
      end
    check("R6 single sync under hold", syncs, 1);
    check("R6 sync after fill clocks", k >= 1, 1);
    if (k >= 0) check_byte_bits("R6 byte bits under hold", k + 1, 8'h3C);
    check("R5 closing clock low", fs_log[nclk-1] + sd_log[nclk-1], 0);
    check("R6 loopback byte", rx_log[rx0], 8'h3C);
  endtask

  task automatic t_disable();
    int rx0;
    loop_on = 1'b1; half_div = 8'd1; hold_clk = 1'b0;
    clear_logs();
    send_byte(8'hFF);
    while (nclk < 5) @(negedge clk);
    rx0 = nrx;
    enable = 1'b0;
    @(negedge clk);
    check("R9 sclk off", sclk, 0);
    check("R9 tx_fs off", tx_fs, 0);
    check("R9 tx_sd off", tx_sd, 0);
    check("R9 tx_ready off", tx_ready, 0);
    enable = 1'b1;
    clear_logs();
    repeat (40) @(negedge clk);
    check("R9 nothing sent after re-enable", nclk, 0);
    check("R9 partial rx byte dropped", nrx, rx0);
    send_byte(8'h5A);
    wait_quiet();
    check("R9 fresh byte received", nrx - rx0, 1);
    check("R9 fresh byte value", rx_log[rx0], 8'h5A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    enable = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_hold_rx();
    t_hold_tx();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule